// File: doc/BRIEF.md
# Controlled Phase Accumulator

This block is the phase engine of a numerically controlled oscillator. A 32-bit accumulator adds a stored increment to itself on every clock and wraps modulo 2^32, so the top bits ramp at a rate of increment × f_clk / 2^32. For example, an increment of 0x2000_0000 repeats every eight clocks. The increment sits in an input register. That register takes one of two 32-bit frequency words when a transfer strobe arrives, so the rate changes on a single clock edge.

Three active-low controls steer the engine:
- **Transfer** copies the chosen word into the increment register.
- **Load** forces the accumulator feedback to zero for one step, so the accumulator restarts from the increment value.
- **Step enable** lets the accumulator advance. While it is inactive, the accumulator freezes.

Each control passes through its own fixed-length delay line before it acts. This lets an upstream word-assembly stage settle first. The most significant 13 bits of the phase leave the block through a register, ready for a sine lookup stage.

Top module: `phase_accum_ctrl`

## Requirements
- R1: The accumulator adds the increment register on every enabled, non-load edge, modulo 2^32 with no carry out. `phase_o` equals bits 31:19 of the accumulator one edge later.
- R2: If `xfer_n` is sampled low at edge k, the increment register holds the selected word after edge k+4. In every other case, the increment register keeps its value even when the word inputs change.
- R3: `sel_b` is delayed together with `xfer_n`. A 1 selects `freq_b` and a 0 selects `freq_a`.
- R4: If `load_n` is sampled low at edge k and stepping is enabled, the accumulator equals the increment register value after edge k+5. The old phase is discarded because the feedback is zeroed.
- R5: If `step_en_n` is sampled high at edge k, the accumulator keeps its value through edge k+4. This hold takes priority over a load that becomes effective on the same edge.
- R6: A low `rst_n` at an edge clears the accumulator, the increment register and `phase_o`. It also fills every delay line with its inactive value: high for the strobes and 0 for `sel_b`. As a result, stepping stays off for four edges after reset, whatever the inputs are.
- R7: Suppose `xfer_n` and `load_n` are both sampled low at edge k while stepping is enabled. Then `phase_o` shows the top 13 bits of the new word after edge k+6. With word 0x2000_0000, `phase_o` reads 0x400 and then advances by 0x400 every edge, returning to 0x400 eight edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_a | input | 32 | Frequency word chosen when `sel_b` is 0; hold stable around transfers |
| freq_b | input | 32 | Frequency word chosen when `sel_b` is 1; hold stable around transfers |
| sel_b | input | 1 | Word select, delayed with the transfer strobe |
| xfer_n | input | 1 | Transfer strobe, active low, effective after four edges |
| load_n | input | 1 | Feedback-zero strobe, active low, effective after five edges |
| step_en_n | input | 1 | Step enable, active low, effective after four edges |
| phase_o | output | 13 | Registered top 13 bits of the accumulator |

## Verification
The embedded assertions check four behaviours on every cycle:
- a frozen accumulator does not move when hold is effective;
- the accumulator equals the increment after an effective load;
- the increment register is untouched without a transfer and takes the selected word on one;
- the output register trails the accumulator by one edge.

They work on the already-delayed controls, so they cannot see the delay lengths. Only the bench can show those: the exact edge on which each strobe acts, the six-edge path from transfer to output, the wrap of the ramp, and the start-up hold after reset. It does so by comparing `phase_o` on every edge against a model built from the requirements.

// File: rtl/pa_pkg.sv
// Package pa_pkg
// Shared sizes and delay lengths of the controlled phase accumulator.
// Assumes: users take these as defaults and may override the module parameters.
package pa_pkg;
    localparam int ACC_W_DEF    = 32;
    localparam int PHASE_W_DEF  = 13;
    localparam int XFER_DLY_DEF = 4;
    localparam int LOAD_DLY_DEF = 5;
    localparam int STEP_DLY_DEF = 4;

    // Control bundle after the delay lines, active-high meaning
    typedef struct packed {
        logic xfer;
        logic sel_b;
        logic zero_fb;
        logic hold;
    } pa_ctrl_t;
endpackage

// File: rtl/pa_delay_line.sv
// Module pa_delay_line
// Fixed-length shift pipeline of W-bit values. A value sampled at edge k
// appears on dout after edge k+DEPTH-1, so the consumer acts at edge k+DEPTH.
// Assumes: DEPTH >= 1, synchronous active-low reset to RST_VAL.
module pa_delay_line #(
    parameter int             DEPTH   = 4,
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = DEPTH - 1;

    logic [W-1:0] stage_q [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                // Capture the incoming control value
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= din;
                end
            end else begin : g_body
                // Pass the value one stage further down the line
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[LAST];
endmodule

// File: rtl/pa_input_reg.sv
// Module pa_input_reg
// Increment register of the accumulator: picks one of two words on an
// effective transfer and keeps it otherwise.
// Assumes: word inputs are stable on the edge where the transfer acts.
module pa_input_reg #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer,
    input  logic             sel_b,
    input  logic [ACC_W-1:0] word_a,
    input  logic [ACC_W-1:0] word_b,
    output logic [ACC_W-1:0] inc_o
);
    logic [ACC_W-1:0] pick;

    // Choose between the two frequency words
    always_comb pick = sel_b ? word_b : word_a;

    // Update the increment only on an effective transfer
    always_ff @(posedge clk) begin
        if (!rst_n)    inc_o <= '0;
        else if (xfer) inc_o <= pick;
    end

    AST_INREG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> inc_o == $past(inc_o)); // R2
    AST_INREG_PICK_B: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && sel_b) |=> inc_o == $past(word_b)); // R3
    AST_INREG_PICK_A: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !sel_b) |=> inc_o == $past(word_a)); // R3
endmodule

// File: rtl/pa_accum.sv
// Module pa_accum
// Wrapping accumulator with hold and feedback-zero, plus the phase output register.
// Assumes: hold has priority over zero_fb; the sum wraps modulo 2^ACC_W.
module pa_accum #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               zero_fb,
    input  logic [ACC_W-1:0]   inc,
    output logic [ACC_W-1:0]   acc_o,
    output logic [PHASE_W-1:0] phase_o
);
    localparam int PH_LSB = ACC_W - PHASE_W;

    logic [ACC_W-1:0] feedback;
    logic [ACC_W-1:0] sum;

    // Zero the feedback path when a load is effective
    always_comb feedback = zero_fb ? '0 : acc_o;

    // Modulo add, the carry out is dropped
    always_comb sum = feedback + inc;

    // Advance the accumulator unless held
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_o <= '0;
        else if (!hold) acc_o <= sum;
    end

    // Register the phase MSBs for the downstream lookup
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= '0;
        else        phase_o <= acc_o[ACC_W-1:PH_LSB];
    end

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> acc_o == $past(acc_o)); // R5
    AST_LOAD_TAKES_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && zero_fb) |=> acc_o == $past(inc)); // R4
endmodule

// File: rtl/phase_accum_ctrl.sv
// Module phase_accum_ctrl
// Top of the controlled phase accumulator: delays each control by its own
// fixed depth, then drives the increment register and the accumulator.
// Assumes: synchronous active-low reset; frequency words stable around transfers.
module phase_accum_ctrl
    import pa_pkg::*;
#(
    parameter int ACC_W    = ACC_W_DEF,
    parameter int PHASE_W  = PHASE_W_DEF,
    parameter int XFER_DLY = XFER_DLY_DEF,
    parameter int LOAD_DLY = LOAD_DLY_DEF,
    parameter int STEP_DLY = STEP_DLY_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   freq_a,
    input  logic [ACC_W-1:0]   freq_b,
    input  logic               sel_b,
    input  logic               xfer_n,
    input  logic               load_n,
    input  logic               step_en_n,
    output logic [PHASE_W-1:0] phase_o
);
    localparam int PH_LSB = ACC_W - PHASE_W;

    logic [1:0]       xfer_pair_d;
    logic             load_n_d;
    logic             step_en_n_d;
    pa_ctrl_t         ctrl;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] acc;

    // Transfer strobe travels with its word select
    pa_delay_line #(.DEPTH(XFER_DLY), .W(2), .RST_VAL(2'b01)) u_xfer_dly (
        .clk(clk), .rst_n(rst_n), .din({sel_b, xfer_n}), .dout(xfer_pair_d)
    );

    pa_delay_line #(.DEPTH(LOAD_DLY), .W(1), .RST_VAL(1'b1)) u_load_dly (
        .clk(clk), .rst_n(rst_n), .din(load_n), .dout(load_n_d)
    );

    pa_delay_line #(.DEPTH(STEP_DLY), .W(1), .RST_VAL(1'b1)) u_step_dly (
        .clk(clk), .rst_n(rst_n), .din(step_en_n), .dout(step_en_n_d)
    );

    // Turn the delayed active-low strobes into active-high controls
    always_comb begin
        ctrl.xfer    = ~xfer_pair_d[0];
        ctrl.sel_b   = xfer_pair_d[1];
        ctrl.zero_fb = ~load_n_d;
        ctrl.hold    = step_en_n_d;
    end

    pa_input_reg #(.ACC_W(ACC_W)) u_inreg (
        .clk(clk), .rst_n(rst_n), .xfer(ctrl.xfer), .sel_b(ctrl.sel_b),
        .word_a(freq_a), .word_b(freq_b), .inc_o(inc)
    );

    pa_accum #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .hold(ctrl.hold), .zero_fb(ctrl.zero_fb),
        .inc(inc), .acc_o(acc), .phase_o(phase_o)
    );

    AST_PHASE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_o == $past(acc[ACC_W-1:PH_LSB])); // R1
endmodule

// File: tb/phase_accum_ctrl_tb.sv
// Directed bench for phase_accum_ctrl with a per-edge reference model.
module phase_accum_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] freq_a, freq_b;
    logic        sel_b, xfer_n, load_n, step_en_n;
    logic [12:0] phase_o;

    int n_run  = 0;
    int n_fail = 0;

    // Reference state built from the requirements
    logic        hx [4];
    logic        hs [4];
    logic        hl [5];
    logic        he [4];
    logic [31:0] m_acc, m_inc;
    logic [12:0] m_out;

    always #4 clk = ~clk;

    phase_accum_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .freq_a(freq_a), .freq_b(freq_b),
        .sel_b(sel_b), .xfer_n(xfer_n), .load_n(load_n),
        .step_en_n(step_en_n), .phase_o(phase_o)
    );

    // Reference model: R2 edge k+4, R4 edge k+5, R5 edge k+4, R6 reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin hx[i] <= 1'b1; hs[i] <= 1'b0; he[i] <= 1'b1; end
            for (int i = 0; i < 5; i++) hl[i] <= 1'b1;
            m_acc <= '0; m_inc <= '0; m_out <= '0;
        end else begin
            hx[0] <= xfer_n; hs[0] <= sel_b; he[0] <= step_en_n; hl[0] <= load_n;
            for (int i = 1; i < 4; i++) begin hx[i] <= hx[i-1]; hs[i] <= hs[i-1]; he[i] <= he[i-1]; end
            for (int i = 1; i < 5; i++) hl[i] <= hl[i-1];
            m_out <= m_acc[31:19];
            if (!he[3]) m_acc <= (hl[4] ? m_acc : 32'h0) + m_inc;
            if (!hx[3]) m_inc <= hs[3] ? freq_b : freq_a;
        end
    end

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: phase_o=%h expected %h", req, act, exp);
        end
    endtask

    // One edge, then compare the output against the model (R1)
    task automatic tick();
        @(posedge clk); #1;
        check("R1 model", phase_o, m_out);
    endtask

    task automatic idle_ctrl();
        xfer_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step_en_n = 1'b0; idle_ctrl(); sel_b = 1'b0;
        freq_a = 32'h0100_0000; freq_b = 32'h0;
        tick(); tick();
        check("R6 reset", phase_o, 13'h0);
        rst_n = 1'b1;
        xfer_n = 1'b0;           // transfer right after reset
        tick(); idle_ctrl();
        tick(); tick();
        check("R6 start hold", phase_o, 13'h0);
        for (int i = 0; i < 6; i++) tick();
    endtask

    // Transfer + load of 0x2000_0000, exact edge and wrap (R7, R4)
    task automatic t_freq_restart();
        freq_a = 32'h2000_0000; sel_b = 1'b0;
        xfer_n = 1'b0; load_n = 1'b0;
        tick(); idle_ctrl();
        for (int i = 0; i < 6; i++) tick();
        check("R7 first", phase_o, 13'h400);
        check("R4 restart", phase_o, 13'h400);
        tick();
        check("R7 step", phase_o, 13'h800);
        for (int i = 0; i < 7; i++) tick();
        check("R1 wrap", phase_o, 13'h400);
    endtask

    // Word inputs change without a transfer: rate unchanged (R2)
    task automatic t_no_xfer();
        logic [12:0] p0;
        freq_a = 32'h0008_0000;
        for (int i = 0; i < 6; i++) tick();
        p0 = phase_o;
        tick();
        check("R2 keep", phase_o - p0, 13'h400);
    endtask

    // Select the second word (R3)
    task automatic t_sel_b();
        freq_b = 32'h0008_0000; freq_a = 32'h1234_5678; sel_b = 1'b1;
        xfer_n = 1'b0; load_n = 1'b0;
        tick(); idle_ctrl(); sel_b = 1'b0;
        for (int i = 0; i < 6; i++) tick();
        check("R3 sel_b", phase_o, 13'h001);
        tick();
        check("R3 step", phase_o, 13'h002);
    endtask

    // Hold overrides a simultaneous load (R5)
    task automatic t_hold();
        logic [12:0] p4;
        freq_a = 32'h2000_0000; sel_b = 1'b0;
        xfer_n = 1'b0;
        tick(); idle_ctrl();
        for (int i = 0; i < 8; i++) tick();
        step_en_n = 1'b1; load_n = 1'b0;          // edge k
        tick(); load_n = 1'b1;
        tick(); tick(); tick(); step_en_n = 1'b0; // high for edges k..k+3
        tick();                                   // edge k+4
        p4 = phase_o;
        tick(); tick(); tick(); tick();           // edge k+8
        check("R5 hold", phase_o, p4);
        for (int i = 0; i < 6; i++) tick();
    endtask

    initial begin
        t_reset();
        t_freq_restart();
        t_no_xfer();
        t_sel_b();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule